// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

The block routes a bank of external interrupt lines to a single delivery channel. Each line owns one two-word redirection entry. The entry holds a vector number, a destination identifier, a destination-mode flag, a polarity select, a trigger-mode select and a mask. Software never addresses the entries directly. It first writes an internal register number into a select register, and then reads or writes that register through a data window.

Each line is compared against its programmed polarity. An edge-mode entry latches one request per inactive-to-active transition. A level-mode entry requests while its line is active. A level entry also carries an in-service flag. Acceptance of a delivery sets the flag, and only an end-of-interrupt write whose vector matches the entry clears it. When several entries request at once, the lowest entry index is offered first on a valid/ready delivery output. That output carries the vector, the destination and the destination mode.

Top module: `irq_redir`

## Requirements
- R1: After reset every entry low word reads 0x00010000 (masked, edge, active-high, vector 0) and every high word reads 0. The select register reads 0, the ID register reads 0 and `dlv_valid` is low.
- R2: A bus write to byte offset 0x00 loads the 8-bit select register, which reads back at offset 0x00. Offset 0x10 reads or writes the internal register chosen by the select value. Any other offset except 0x40 reads 0, and writes to it change nothing.
- R3: Internal register 0x00 keeps only bits 27:24 of a write and reads 0 elsewhere. Internal register 0x01 reads 0x00170020 (entry count minus one in bits 23:16, version 0x20 in bits 7:0) and ignores writes. Internal registers that map to nothing read 0.
- R4: Entry n has its low word at internal register 0x10+2n and its high word at 0x10+2n+1. In the low word, bits 7:0 are the vector, bit 11 is the logical-destination flag, bit 13 selects active-low, bit 15 selects level mode and bit 16 is the mask. All other low-word bits read 0, except bit 12, which is read-only and reads 1 while that entry requests delivery. In the high word, bits 31:24 hold the destination and the other bits read 0.
- R5: An unmasked edge-mode entry latches one request on each inactive-to-active transition of its line and delivers it exactly once. A line held active afterwards does not deliver again.
- R6: A masked entry never requests delivery. An edge that arrives while the entry is masked is discarded. Setting the mask also drops an edge request that has not yet been delivered.
- R7: An unmasked level-mode entry requests delivery while its line is active and its in-service flag is clear. This includes a line that is already active at the moment the entry is unmasked.
- R8: Acceptance of a level-mode delivery sets that entry's in-service flag, which blocks further requests. A write to offset 0x40 whose bits 7:0 equal the vector of a level-mode entry clears that entry's flag. A non-matching vector clears nothing.
- R9: `dlv_valid` is high while any entry requests. `dlv_vector`, `dlv_dest` and `dlv_logical` then come from the lowest-index requesting entry, and that entry is accepted on a clock edge with `dlv_ready` high.
- R10: With the active-low bit set, a low line level counts as active. With the bit clear, a high level counts as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 24 | Interrupt lines, synchronous to `clk` |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Delivery accepted by the consumer |
| dlv_vector | output | 8 | Vector of the offered request |
| dlv_dest | output | 8 | Destination of the offered request |
| dlv_logical | output | 1 | Destination is a logical identifier |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`, with at most one change per cycle. They also assume that a low-word write does not land in the same cycle as an acceptance for that same entry. The bench drives every line and bus signal on the falling edge only. It reprograms an entry only while `dlv_ready` is low. Reads are sampled shortly after a falling edge, once the combinational read path has settled.

// File: rtl/irq_redir_pkg.sv
// Shared types and constants of the indexed interrupt redirection controller.
// Assumes an 8-bit internal register select and a 32-bit data window.
package irq_redir_pkg;

    // Configuration held by one redirection entry
    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic       logical;
        logic [7:0] vector;
        logic [7:0] dest;
    } rte_cfg_t;

    localparam logic [6:0] OFF_INDEX  = 7'h00;
    localparam logic [6:0] OFF_WINDOW = 7'h10;
    localparam logic [6:0] OFF_EOI    = 7'h40;

    localparam logic [7:0] IDX_ID    = 8'h00;
    localparam logic [7:0] IDX_VER   = 8'h01;
    localparam logic [7:0] IDX_TABLE = 8'h10;

    localparam int B_MASK    = 16;
    localparam int B_LEVEL   = 15;
    localparam int B_ACTLOW  = 13;
    localparam int B_STATUS  = 12;
    localparam int B_LOGICAL = 11;

    localparam rte_cfg_t RTE_RESET = '{mask: 1'b1, level: 1'b0, act_low: 1'b0,
                                       logical: 1'b0, vector: 8'h00, dest: 8'h00};

endpackage

// File: rtl/irq_redir_regs.sv
// Register front end: select register, ID/version registers, data window
// decode, table write strobes and end-of-interrupt strobe.
// Assumes N_LINES <= 120 so that every table index fits the 8-bit select.
module irq_redir_regs #(
    parameter int         N_LINES = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [6:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [N_LINES-1:0][31:0]  ent_lo,
    input  logic [N_LINES-1:0][31:0]  ent_hi,
    output logic [N_LINES-1:0]        wr_lo,
    output logic [N_LINES-1:0]        wr_hi,
    output logic                      eoi_wr,
    output logic [7:0]                eoi_vec
);
    import irq_redir_pkg::*;

    localparam int TBL_LAST = 16 + 2 * N_LINES - 1;

    logic [7:0]  index_q;
    logic [3:0]  id_q;
    logic        hit_index;
    logic        hit_window;
    logic        in_tbl;
    logic [7:0]  rel;
    logic [6:0]  sel_ent;
    logic        sel_hi;
    logic [31:0] win_data;

    assign hit_index  = bus_wr && (bus_addr == OFF_INDEX);
    assign hit_window = bus_wr && (bus_addr == OFF_WINDOW);
    assign in_tbl     = (index_q >= IDX_TABLE) && (index_q <= 8'(TBL_LAST));
    assign rel        = index_q - IDX_TABLE;
    assign sel_ent    = rel[7:1];
    assign sel_hi     = rel[0];
    assign eoi_wr     = bus_wr && (bus_addr == OFF_EOI);
    assign eoi_vec    = bus_wdata[7:0];

    // Select register load
    always_ff @(posedge clk) begin
        if (!rst_n)          index_q <= 8'h00;
        else if (hit_index)  index_q <= bus_wdata[7:0];
    end

    // ID register load through the window
    always_ff @(posedge clk) begin
        if (!rst_n)                                  id_q <= 4'h0;
        else if (hit_window && index_q == IDX_ID)    id_q <= bus_wdata[27:24];
    end

    // One write strobe per table word
    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_strobe
            assign wr_lo[i] = hit_window && in_tbl && !sel_hi && (sel_ent == 7'(i));
            assign wr_hi[i] = hit_window && in_tbl &&  sel_hi && (sel_ent == 7'(i));
        end
    endgenerate

    // Window read mux over ID, version and table words
    always_comb begin
        win_data = 32'h0;
        if (index_q == IDX_ID) begin
            win_data = {4'h0, id_q, 24'h0};
        end else if (index_q == IDX_VER) begin
            win_data = {8'h00, 8'(N_LINES - 1), 8'h00, VERSION};
        end else if (in_tbl) begin
            for (int i = 0; i < N_LINES; i++) begin
                if (sel_ent == 7'(i)) win_data = sel_hi ? ent_hi[i] : ent_lo[i];
            end
        end
    end

    // Bus read mux by byte offset
    always_comb begin
        case (bus_addr)
            OFF_INDEX:  bus_rdata = {24'h0, index_q};
            OFF_WINDOW: bus_rdata = win_data;
            default:    bus_rdata = 32'h0;
        endcase
    end

    a_r2_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_index |=> $stable(index_q));
    a_r3_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_window && index_q == IDX_ID) |=> $stable(id_q));
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi}));

endmodule

// File: rtl/irq_redir_entry.sv
// One redirection entry: configuration storage, polarity, edge capture,
// level in-service tracking and the request seen by the arbiter.
// Assumes irq_line is synchronous to clk.
module irq_redir_entry (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_line,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [31:0]               wdata,
    input  logic                      eoi_wr,
    input  logic [7:0]                eoi_vec,
    input  logic                      acc,
    output logic                      req,
    output irq_redir_pkg::rte_cfg_t   cfg,
    output logic [31:0]               rd_lo,
    output logic [31:0]               rd_hi
);
    import irq_redir_pkg::*;

    logic act;
    logic prev_act;
    logic edge_now;
    logic pend;
    logic insvc;
    logic eoi_hit;

    assign act      = irq_line ^ cfg.act_low;
    assign edge_now = act && !prev_act;
    assign eoi_hit  = eoi_wr && cfg.level && (eoi_vec == cfg.vector);
    assign req      = !cfg.mask && (cfg.level ? (act && !insvc) : pend);

    assign rd_lo = {15'h0, cfg.mask, cfg.level, 1'b0, cfg.act_low, req,
                    cfg.logical, 3'b000, cfg.vector};
    assign rd_hi = {cfg.dest, 24'h0};

    // Configuration words written through the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= RTE_RESET;
        end else begin
            if (wr_lo) begin
                cfg.mask    <= wdata[B_MASK];
                cfg.level   <= wdata[B_LEVEL];
                cfg.act_low <= wdata[B_ACTLOW];
                cfg.logical <= wdata[B_LOGICAL];
                cfg.vector  <= wdata[7:0];
            end
            if (wr_hi) cfg.dest <= wdata[31:24];
        end
    end

    // Previous active state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_act <= 1'b0;
        else        prev_act <= act;
    end

    // Edge request latch, dropped while masked or in level mode
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend <= 1'b0;
        else if (cfg.level || cfg.mask)  pend <= 1'b0;
        else if (edge_now)               pend <= 1'b1;
        else if (acc)                    pend <= 1'b0;
    end

    // Level in-service flag, set on acceptance, cleared by matching EOI
    always_ff @(posedge clk) begin
        if (!rst_n)                  insvc <= 1'b0;
        else if (eoi_hit)            insvc <= 1'b0;
        else if (cfg.level && acc)   insvc <= 1'b1;
    end

    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mask |-> !req);
    a_r8_insvc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && insvc) |-> !req);
    a_r8_insvc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && insvc && !eoi_hit) |=> insvc);
    a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && acc && !edge_now && !wr_lo) |=> !req);

endmodule

// File: rtl/irq_redir_arb.sv
// Fixed-priority selector: grants the lowest-index requesting entry.
// Assumes requests are stable between clock edges.
module irq_redir_arb #(
    parameter int N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req,
    output logic [N_LINES-1:0] grant,
    output logic               any
);
    // Lowest index wins
    always_comb begin
        grant = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req[i]) grant = N_LINES'(1) << i;
        end
    end

    assign any = |req;

    a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

    generate
        for (genvar i = 1; i < N_LINES; i++) begin : g_prio
            a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
                grant[i] |-> (req[i-1:0] == '0));
        end
    endgenerate

endmodule

// File: rtl/irq_redir.sv
// Indexed interrupt redirection controller top: register front end,
// one entry per line and a fixed-priority delivery channel.
// Assumes irq_in is synchronous to clk.
module irq_redir #(
    parameter int         N_LINES = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [6:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [7:0]         dlv_vector,
    output logic [7:0]         dlv_dest,
    output logic               dlv_logical
);
    import irq_redir_pkg::*;

    logic [N_LINES-1:0][31:0] ent_lo;
    logic [N_LINES-1:0][31:0] ent_hi;
    logic [N_LINES-1:0]       wr_lo;
    logic [N_LINES-1:0]       wr_hi;
    logic [N_LINES-1:0]       req;
    logic [N_LINES-1:0]       grant;
    logic [N_LINES-1:0]       acc;
    rte_cfg_t                 cfg_a [N_LINES];
    logic                     eoi_wr;
    logic [7:0]               eoi_vec;

    irq_redir_regs #(.N_LINES(N_LINES), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_lo(ent_lo),
        .ent_hi(ent_hi), .wr_lo(wr_lo), .wr_hi(wr_hi), .eoi_wr(eoi_wr),
        .eoi_vec(eoi_vec)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_ent
            irq_redir_entry u_ent (
                .clk(clk), .rst_n(rst_n), .irq_line(irq_in[i]),
                .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
                .eoi_wr(eoi_wr), .eoi_vec(eoi_vec), .acc(acc[i]),
                .req(req[i]), .cfg(cfg_a[i]), .rd_lo(ent_lo[i]), .rd_hi(ent_hi[i])
            );
        end
    endgenerate

    irq_redir_arb #(.N_LINES(N_LINES)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any(dlv_valid)
    );

    assign acc = grant & {N_LINES{dlv_ready}};

    // Payload of the granted entry
    always_comb begin
        dlv_vector  = 8'h00;
        dlv_dest    = 8'h00;
        dlv_logical = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (grant[i]) begin
                dlv_vector  = dlv_vector  | cfg_a[i].vector;
                dlv_dest    = dlv_dest    | cfg_a[i].dest;
                dlv_logical = dlv_logical | cfg_a[i].logical;
            end
        end
    end

    a_r9_accept_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != '0) |-> dlv_valid);

endmodule

// File: tb/irq_redir_test.sv
module irq_redir_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = 7'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [23:0] irq_in = 24'h0;
    logic        dlv_valid;
    logic        dlv_ready = 1'b0;
    logic [7:0]  dlv_vector;
    logic [7:0]  dlv_dest;
    logic        dlv_logical;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_redir uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
        .dlv_dest(dlv_dest), .dlv_logical(dlv_logical)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Called at a falling edge, returns at the next falling edge
    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] idx, output logic [31:0] v);
        wr(7'h00, {24'h0, idx});
        bus_addr = 7'h10;
        #1 v = bus_rdata;
    endtask

    task automatic prog(int n, logic [31:0] lo, logic [31:0] hi);
        wr(7'h00, 32'(16 + 2 * n + 1));
        wr(7'h10, hi);
        wr(7'h00, 32'(16 + 2 * n));
        wr(7'h10, lo);
    endtask

    task automatic accept();
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 valid", {31'h0, dlv_valid}, 32'h0);
        bus_addr = 7'h00; #1 check("R1 select", bus_rdata, 32'h0);
        rd(8'h10, v); check("R1 entry0 low", v, 32'h00010000);
        rd(8'h3F, v); check("R1 entry23 high", v, 32'h0);
        rd(8'h00, v); check("R1 id", v, 32'h0);
        rd(8'h01, v); check("R3 version", v, 32'h00170020);
        rd(8'h40, v); check("R3 unmapped index", v, 32'h0);
        bus_addr = 7'h20; #1 check("R2 other offset", bus_rdata, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(7'h00, 32'h0); wr(7'h10, 32'hFFFFFFFF);
        rd(8'h00, v); check("R3 id bits", v, 32'h0F000000);
        wr(7'h00, 32'h1); wr(7'h10, 32'h0);
        rd(8'h01, v); check("R3 version ro", v, 32'h00170020);
        wr(7'h00, 32'h10); wr(7'h10, 32'hFFFFFFFF);
        rd(8'h10, v); check("R4 low fields", v, 32'h0001A8FF);
        wr(7'h10, 32'h00010000);
        wr(7'h00, 32'h11); wr(7'h10, 32'hFFFFFFFF);
        rd(8'h11, v); check("R4 high field", v, 32'hFF000000);
        wr(7'h10, 32'h0);
        wr(7'h20, 32'h0000_0005);
        bus_addr = 7'h00; #1 check("R2 select kept", bus_rdata, 32'h11);
        @(negedge clk);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        prog(3, 32'h00000041, 32'h05000000);
        irq_in[3] = 1'b1; @(negedge clk);
        check("R5 valid", {31'h0, dlv_valid}, 32'h1);
        check("R9 vector", {24'h0, dlv_vector}, 32'h41);
        check("R9 dest", {24'h0, dlv_dest}, 32'h05);
        rd(8'h16, v); check("R4 status bit", v, 32'h00001041);
        accept();
        check("R5 once", {31'h0, dlv_valid}, 32'h0);
        repeat (3) @(negedge clk);
        check("R5 held line", {31'h0, dlv_valid}, 32'h0);
        irq_in[3] = 1'b0; @(negedge clk);
    endtask

    task automatic t_mask();
        wr(7'h00, 32'h16); wr(7'h10, 32'h00010041);
        irq_in[3] = 1'b1; @(negedge clk); irq_in[3] = 1'b0; @(negedge clk);
        wr(7'h10, 32'h00000041); @(negedge clk);
        check("R6 masked edge lost", {31'h0, dlv_valid}, 32'h0);
        irq_in[3] = 1'b1; @(negedge clk); irq_in[3] = 1'b0;
        check("R6 unmasked edge", {31'h0, dlv_valid}, 32'h1);
        wr(7'h10, 32'h00010041);
        check("R6 mask blocks", {31'h0, dlv_valid}, 32'h0);
        wr(7'h10, 32'h00000041); @(negedge clk);
        check("R6 pending dropped", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_level();
        prog(5, 32'h00008050, 32'h07000000);
        irq_in[5] = 1'b1; @(negedge clk);
        check("R7 level valid", {31'h0, dlv_valid}, 32'h1);
        check("R7 level vector", {24'h0, dlv_vector}, 32'h50);
        accept();
        check("R8 in service", {31'h0, dlv_valid}, 32'h0);
        wr(7'h40, 32'h51);
        check("R8 wrong eoi", {31'h0, dlv_valid}, 32'h0);
        wr(7'h40, 32'h50);
        check("R8 eoi redeliver", {31'h0, dlv_valid}, 32'h1);
        accept();
        irq_in[5] = 1'b0;
        wr(7'h40, 32'h50);
        check("R7 line idle", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_polarity();
        prog(6, 32'h0001A060, 32'h06000000);
        check("R10 masked low line", {31'h0, dlv_valid}, 32'h0);
        wr(7'h10, 32'h0000A060);
        check("R7 unmask active", {31'h0, dlv_valid}, 32'h1);
        check("R10 low active vector", {24'h0, dlv_vector}, 32'h60);
        accept();
        irq_in[6] = 1'b1;
        wr(7'h40, 32'h60);
        check("R10 high inactive", {31'h0, dlv_valid}, 32'h0);
    endtask

    task automatic t_priority();
        prog(9, 32'h00000890, 32'h09000000);
        prog(2, 32'h00000022, 32'h02000000);
        irq_in[9] = 1'b1; irq_in[2] = 1'b1; @(negedge clk);
        irq_in[9] = 1'b0; irq_in[2] = 1'b0;
        check("R9 low index first", {24'h0, dlv_vector}, 32'h22);
        check("R9 dest first", {24'h0, dlv_dest}, 32'h02);
        check("R9 physical mode", {31'h0, dlv_logical}, 32'h0);
        accept();
        check("R9 second vector", {24'h0, dlv_vector}, 32'h90);
        check("R9 second dest", {24'h0, dlv_dest}, 32'h09);
        check("R9 logical mode", {31'h0, dlv_logical}, 32'h1);
        accept();
        check("R9 drained", {31'h0, dlv_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_edge();
        t_mask();
        t_level();
        t_polarity();
        t_priority();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule